// File: doc/BRIEF.md
# Partial-Width Register File

This block holds eight 32-bit general-purpose registers for a small datapath core. Each register can be read or written whole, or through its low 16-bit half. The first four registers also offer two byte views, a low byte and a high byte, each of which can be addressed on its own. Every narrow write merges into the wider register and leaves the bits outside the addressed view exactly as they were.

Two read ports return views with no clock delay. Each read port has its own register index and size selector, and the result is zero-extended to 32 bits.

A single command port performs one of two writes per clock:
- An immediate load writes a constant at byte, half or word width.
- A register-to-register move copies one view into another view.

A move whose source and destination sizes differ is refused. So is any command that carries the reserved size code. A refused command writes nothing and raises a one-cycle error flag.

Top module: `pwreg_file`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to zero and clears `size_err`.
- R2: Size code 2 (word) reads and writes all 32 bits of the register selected by index 0..7 (0=A, 1=C, 2=D, 3=B, 4=SP, 5=BP, 6=SI, 7=DI).
- R3: A write with size code 1 (half) replaces bits 15:0 of the destination and keeps bits 31:16.
- R4: With size code 0 (byte), indexes 0..3 select bits 7:0 of registers 0..3, and indexes 4..7 select bits 15:8 of registers 0..3. A byte write changes only the selected 8 bits, and the immediate bits above the view width are ignored.
- R5: A half read returns bits 15:0 and a byte read returns the selected byte, each zero-extended to 32 bits.
- R6: Command code 2 (move) copies the source view into the destination view. The source register is unchanged unless it is the same physical register as the destination.
- R7: A move with unequal source and destination size codes writes nothing, and `size_err` is high for the cycle after the command.
- R8: A command with command code 1 (immediate load) or 2 (move) that uses size code 3 in any size field it uses writes nothing and raises `size_err` for one cycle.
- R9: Reads are combinational. A read in the same cycle as a write to that register returns the old value, and the new value is visible after the clock edge.
- R10: The two read ports are independent. Each returns the view selected by its own index and size.
- R11: Command codes 0 (idle) and 3 (reserved) write nothing and leave `size_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Command: 0 idle, 1 immediate load, 2 move, 3 reserved |
| cmd_dst | input | 3 | Destination register/view index |
| cmd_dst_sz | input | 2 | Destination size: 0 byte, 1 half, 2 word, 3 invalid |
| cmd_src | input | 3 | Source register/view index (move only) |
| cmd_src_sz | input | 2 | Source size (move only) |
| cmd_imm | input | 32 | Immediate constant, low-aligned |
| rd_a_idx | input | 3 | Read port A index |
| rd_a_sz | input | 2 | Read port A size |
| rd_a_data | output | 32 | Read port A data, zero-extended |
| rd_b_idx | input | 3 | Read port B index |
| rd_b_sz | input | 2 | Read port B size |
| rd_b_data | output | 32 | Read port B data, zero-extended |
| size_err | output | 1 | Registered flag, high for the cycle after a refused command |

## Verification
The hardest case to reach is a move between the two byte views of one physical register. Such a move, for example from the low byte of A into the high byte of A, must read and rewrite the same register in one cycle. The bench first gives A distinct byte values with an immediate word load. It then issues that move and compares every register against a model, which shows both that the merge is right and that no other register moved. Refused moves are placed between valid ones, so that a write leaking through on an error would change a known value.

// File: rtl/pwreg_pkg.sv
package pwreg_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOADI = 2'd1,
    OP_MOVE  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;
endpackage

// File: rtl/pwreg_view_rd.sv
module pwreg_view_rd
  import pwreg_pkg::*;
#(
  parameter int W     = 32,
  parameter int HW    = 16,
  parameter int BW    = 8,
  parameter int NREG  = 8,
  parameter int NBREG = 4,
  parameter int IDXW  = $clog2(NREG)
) (
  input  logic [NREG-1:0][W-1:0] regs_i,
  input  logic [IDXW-1:0]        idx_i,
  input  logic [1:0]             size_i,
  output logic [W-1:0]           data_o
);
  logic            is_hi;
  logic [IDXW-1:0] byte_phys;

  // Upper half of the byte index space maps onto bits 2*BW-1:BW of the low registers
  assign is_hi     = (idx_i >= IDXW'(NBREG));
  assign byte_phys = is_hi ? (idx_i - IDXW'(NBREG)) : idx_i;

  always_comb begin
    data_o = '0;
    case (size_i)
      SZ_BYTE: begin
        if (is_hi) data_o[BW-1:0] = regs_i[byte_phys][2*BW-1:BW];
        else       data_o[BW-1:0] = regs_i[byte_phys][BW-1:0];
      end
      SZ_HALF: data_o[HW-1:0] = regs_i[idx_i][HW-1:0];
      SZ_WORD: data_o         = regs_i[idx_i];
      default: data_o         = '0;
    endcase
  end
endmodule

// File: rtl/pwreg_merge.sv
module pwreg_merge
  import pwreg_pkg::*;
#(
  parameter int W  = 32,
  parameter int HW = 16,
  parameter int BW = 8
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] val_i,
  input  logic [1:0]   size_i,
  input  logic         hi_i,
  output logic [W-1:0] new_o
);
  always_comb begin
    new_o = old_i;
    case (size_i)
      SZ_BYTE: begin
        if (hi_i) new_o[2*BW-1:BW] = val_i[BW-1:0];
        else      new_o[BW-1:0]    = val_i[BW-1:0];
      end
      SZ_HALF: new_o[HW-1:0] = val_i[HW-1:0];
      SZ_WORD: new_o         = val_i;
      default: new_o         = old_i;
    endcase
  end

  always_comb begin
    if (size_i == SZ_HALF || size_i == SZ_BYTE)
      AST_UPPER_KEPT: assert (new_o[W-1:HW] == old_i[W-1:HW]) else $error("upper half changed on narrow write"); // R3
    if (size_i == SZ_BYTE && !hi_i)
      AST_LOW_BYTE_ONLY: assert (new_o[W-1:BW] == old_i[W-1:BW]) else $error("bits above low byte changed"); // R4
    if (size_i == SZ_BYTE && hi_i)
      AST_HIGH_BYTE_ONLY: assert (new_o[BW-1:0] == old_i[BW-1:0]) else $error("low byte changed on high-byte write"); // R4
  end
endmodule

// File: rtl/pwreg_cmd_chk.sv
module pwreg_cmd_chk
  import pwreg_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic [1:0] dst_sz_i,
  input  logic [1:0] src_sz_i,
  output logic       write_ok_o,
  output logic       reject_o
);
  logic is_load, is_move, load_bad, move_bad;

  assign is_load  = (op_i == OP_LOADI);
  assign is_move  = (op_i == OP_MOVE);
  assign load_bad = (dst_sz_i == SZ_BAD);
  assign move_bad = (dst_sz_i == SZ_BAD) || (src_sz_i == SZ_BAD) || (dst_sz_i != src_sz_i);

  assign reject_o   = (is_load && load_bad) || (is_move && move_bad);
  assign write_ok_o = (is_load && !load_bad) || (is_move && !move_bad);
endmodule

// File: rtl/pwreg_file.sv
module pwreg_file
  import pwreg_pkg::*;
#(
  parameter int W     = 32,
  parameter int HW    = 16,
  parameter int BW    = 8,
  parameter int NREG  = 8,
  parameter int NBREG = 4,
  parameter int IDXW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      cmd_op,
  input  logic [IDXW-1:0] cmd_dst,
  input  logic [1:0]      cmd_dst_sz,
  input  logic [IDXW-1:0] cmd_src,
  input  logic [1:0]      cmd_src_sz,
  input  logic [W-1:0]    cmd_imm,
  input  logic [IDXW-1:0] rd_a_idx,
  input  logic [1:0]      rd_a_sz,
  output logic [W-1:0]    rd_a_data,
  input  logic [IDXW-1:0] rd_b_idx,
  input  logic [1:0]      rd_b_sz,
  output logic [W-1:0]    rd_b_data,
  output logic            size_err
);
  localparam int NVIEW = 3;   // two read ports plus the move source view
  localparam int VSRC  = 2;

  logic [NREG-1:0][W-1:0] regs_q;

  logic [IDXW-1:0] v_idx  [NVIEW];
  logic [1:0]      v_sz   [NVIEW];
  logic [W-1:0]    v_data [NVIEW];

  assign v_idx[0] = rd_a_idx;
  assign v_sz[0]  = rd_a_sz;
  assign v_idx[1] = rd_b_idx;
  assign v_sz[1]  = rd_b_sz;
  assign v_idx[2] = cmd_src;
  assign v_sz[2]  = cmd_src_sz;

  for (genvar g = 0; g < NVIEW; g++) begin : g_view
    pwreg_view_rd #(
      .W(W), .HW(HW), .BW(BW), .NREG(NREG), .NBREG(NBREG), .IDXW(IDXW)
    ) u_view (
      .regs_i (regs_q),
      .idx_i  (v_idx[g]),
      .size_i (v_sz[g]),
      .data_o (v_data[g])
    );
  end

  assign rd_a_data = v_data[0];
  assign rd_b_data = v_data[1];

  logic write_ok, reject;

  pwreg_cmd_chk u_chk (
    .op_i       (cmd_op),
    .dst_sz_i   (cmd_dst_sz),
    .src_sz_i   (cmd_src_sz),
    .write_ok_o (write_ok),
    .reject_o   (reject)
  );

  // Destination physical register and byte lane
  logic            dst_hi, src_hi;
  logic [IDXW-1:0] dst_phys, src_phys;
  logic [W-1:0]    wr_val, merged;

  assign dst_hi   = (cmd_dst_sz == SZ_BYTE) && (cmd_dst >= IDXW'(NBREG));
  assign dst_phys = dst_hi ? (cmd_dst - IDXW'(NBREG)) : cmd_dst;
  assign src_hi   = (cmd_src_sz == SZ_BYTE) && (cmd_src >= IDXW'(NBREG));
  assign src_phys = src_hi ? (cmd_src - IDXW'(NBREG)) : cmd_src;
  assign wr_val   = (cmd_op == OP_MOVE) ? v_data[VSRC] : cmd_imm;

  pwreg_merge #(.W(W), .HW(HW), .BW(BW)) u_merge (
    .old_i  (regs_q[dst_phys]),
    .val_i  (wr_val),
    .size_i (cmd_dst_sz),
    .hi_i   (dst_hi),
    .new_o  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q   <= '0;
      size_err <= 1'b0;
    end else begin
      size_err <= reject;
      if (write_ok) regs_q[dst_phys] <= merged;
    end
  end

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    size_err |-> $stable(regs_q)) else $error("register changed on refused command"); // R7

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    size_err |-> $past(reject)) else $error("error flag without a refused command"); // R8

  AST_MOVE_SRC_KEPT: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_MOVE && src_phys != dst_phys) |=> (regs_q[$past(src_phys)] == $past(regs_q[src_phys])))
    else $error("move altered its source register"); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_IDLE || cmd_op == OP_RSVD) |=> ($stable(regs_q) && !size_err))
    else $error("idle or reserved command had an effect"); // R11
endmodule

// File: tb/pwreg_file_test.sv
module pwreg_file_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cmd_op, cmd_dst_sz, cmd_src_sz, rd_a_sz, rd_b_sz;
  logic [2:0]  cmd_dst, cmd_src, rd_a_idx, rd_b_idx;
  logic [31:0] cmd_imm, rd_a_data, rd_b_data;
  logic        size_err;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [31:0] exp_r [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwreg_file uut (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_dst_sz(cmd_dst_sz),
    .cmd_src(cmd_src), .cmd_src_sz(cmd_src_sz), .cmd_imm(cmd_imm),
    .rd_a_idx(rd_a_idx), .rd_a_sz(rd_a_sz), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_sz(rd_b_sz), .rd_b_data(rd_b_data), .size_err(size_err)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [2:0] dst, input logic [1:0] dsz,
                     input logic [2:0] src, input logic [1:0] ssz, input logic [31:0] imm);
    @(negedge clk);
    cmd_op = op; cmd_dst = dst; cmd_dst_sz = dsz; cmd_src = src; cmd_src_sz = ssz; cmd_imm = imm;
    @(negedge clk);
    cmd_op = 2'd0;
  endtask

  task automatic read_a(input logic [2:0] idx, input logic [1:0] sz, output logic [31:0] d);
    rd_a_idx = idx; rd_a_sz = sz; #1; d = rd_a_data;
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_b_idx = 3'(i); rd_b_sz = 2'd2; #1;
      check(req, $sformatf("reg %0d word", i), rd_b_data, exp_r[i]);
    end
  endtask

  task automatic t_reset;
    check("R1", "size_err after reset", {31'd0, size_err}, 32'd0);
    check_all("R1");
  endtask

  task automatic t_word;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      exp_r[i] = 32'(32'h9E3779B9 * (i + 1));
      cmd(2'd1, 3'(i), 2'd2, 3'd0, 2'd0, exp_r[i]);
    end
    for (int i = 0; i < 8; i++) begin
      rd_b_idx = 3'(7 - i); rd_b_sz = 2'd2;
      read_a(3'(i), 2'd2, d);
      check("R2", $sformatf("port A word reg %0d", i), d, exp_r[i]);
      check("R10", $sformatf("port B word reg %0d", 7 - i), rd_b_data, exp_r[7 - i]);
    end
  endtask

  task automatic t_half;
    logic [31:0] d;
    cmd(2'd1, 3'd5, 2'd2, 3'd0, 2'd0, 32'hA5A55A5A);
    cmd(2'd1, 3'd5, 2'd1, 3'd0, 2'd0, 32'hFFFF1234);
    exp_r[5] = 32'hA5A51234;
    read_a(3'd5, 2'd1, d);
    check("R5", "half read of BP", d, 32'h00001234);
    check_all("R3");
  endtask

  task automatic t_byte;
    logic [31:0] d;
    cmd(2'd1, 3'd3, 2'd2, 3'd0, 2'd0, 32'h11223344);
    cmd(2'd1, 3'd3, 2'd0, 3'd0, 2'd0, 32'hFFFFFFAA);
    exp_r[3] = 32'h112233AA;
    check_all("R4");
    cmd(2'd1, 3'd7, 2'd0, 3'd0, 2'd0, 32'h000000BB);
    exp_r[3] = 32'h1122BBAA;
    check_all("R4");
    rd_b_idx = 3'd3; rd_b_sz = 2'd0;
    read_a(3'd7, 2'd0, d);
    check("R5", "high byte view idx 7", d, 32'h000000BB);
    check("R10", "port B low byte idx 3", rd_b_data, 32'h000000AA);
    read_a(3'd3, 2'd1, d);
    check("R5", "half view of B", d, 32'h0000BBAA);
  endtask

  task automatic t_move;
    cmd(2'd1, 3'd0, 2'd2, 3'd0, 2'd0, 32'hCAFE7E11);
    exp_r[0] = 32'hCAFE7E11;
    cmd(2'd2, 3'd6, 2'd2, 3'd1, 2'd2, 32'hDEADDEAD);
    exp_r[6] = exp_r[1];
    check_all("R6");
    cmd(2'd2, 3'd2, 2'd0, 3'd4, 2'd0, 32'h0);
    exp_r[2][7:0] = exp_r[0][15:8];
    check_all("R6");
    cmd(2'd2, 3'd5, 2'd1, 3'd4, 2'd1, 32'h0);
    exp_r[5][15:0] = exp_r[4][15:0];
    check_all("R6");
    cmd(2'd2, 3'd4, 2'd0, 3'd0, 2'd0, 32'h0);
    exp_r[0][15:8] = exp_r[0][7:0];
    check("R6", "AL into AH same register", exp_r[0], 32'hCAFE1111);
    check_all("R6");
  endtask

  task automatic t_mismatch;
    cmd(2'd2, 3'd2, 2'd0, 3'd1, 2'd1, 32'h0);
    check("R7", "err after half->byte move", {31'd0, size_err}, 32'd1);
    check_all("R7");
    cmd(2'd2, 3'd6, 2'd1, 3'd7, 2'd2, 32'h0);
    check("R7", "err after word->half move", {31'd0, size_err}, 32'd1);
    check_all("R7");
    cmd(2'd1, 3'd1, 2'd2, 3'd0, 2'd0, 32'h0BADF00D);
    exp_r[1] = 32'h0BADF00D;
    check("R7", "err clears after valid load", {31'd0, size_err}, 32'd0);
    check_all("R7");
  endtask

  task automatic t_bad_size;
    cmd(2'd1, 3'd4, 2'd3, 3'd0, 2'd0, 32'h12345678);
    check("R8", "err after load size 3", {31'd0, size_err}, 32'd1);
    check_all("R8");
    cmd(2'd2, 3'd4, 2'd3, 3'd0, 2'd3, 32'h0);
    check("R8", "err after move size 3", {31'd0, size_err}, 32'd1);
    check_all("R8");
    @(negedge clk);
    check("R8", "err is one cycle", {31'd0, size_err}, 32'd0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    @(negedge clk);
    cmd_op = 2'd1; cmd_dst = 3'd6; cmd_dst_sz = 2'd2; cmd_imm = 32'h5EED5EED;
    read_a(3'd6, 2'd2, d);
    check("R9", "read during write returns old", d, exp_r[6]);
    @(negedge clk);
    cmd_op = 2'd0;
    exp_r[6] = 32'h5EED5EED;
    read_a(3'd6, 2'd2, d);
    check("R9", "read after edge returns new", d, exp_r[6]);
  endtask

  task automatic t_idle;
    cmd(2'd0, 3'd0, 2'd2, 3'd1, 2'd2, 32'hFFFFFFFF);
    check("R11", "idle err", {31'd0, size_err}, 32'd0);
    check_all("R11");
    cmd(2'd3, 3'd0, 2'd2, 3'd1, 2'd3, 32'hFFFFFFFF);
    check("R11", "reserved op err", {31'd0, size_err}, 32'd0);
    check_all("R11");
  endtask

  initial begin
    rst = 1'b1;
    cmd_op = 2'd0; cmd_dst = 3'd0; cmd_dst_sz = 2'd0; cmd_src = 3'd0; cmd_src_sz = 2'd0; cmd_imm = '0;
    rd_a_idx = 3'd0; rd_a_sz = 2'd2; rd_b_idx = 3'd0; rd_b_sz = 2'd2;
    for (int i = 0; i < 8; i++) exp_r[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_word();
    t_half();
    t_byte();
    t_move();
    t_mismatch();
    t_bad_size();
    t_same_cycle();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog (all requirements): actual=still running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule